// File: doc/BRIEF.md
# Automatic Low-Power Entry Controller

This block decides when a DRAM memory controller should drop into a low-power state and when it should come back out. Software, or a control agent, programs it through a small command port. An automatic-mode command picks a power-down or short self-refresh state and sets an idle threshold. From then on the block counts consecutive idle controller clocks. When the count reaches the threshold, it asks the DRAM sequencer to enter the chosen state. While that automatic state is held, a wake indication from new traffic or maintenance (for example calibration) makes the block request an exit at once. Once the controller is idle again, the block rearms the count from zero.

A second path serves the long self-refresh states. An explicit enter command places the memory in a long self-refresh (DDR family) or a long self-refresh power-down (LPDDR family). The memory stays there until an explicit exit command arrives. Every state code is checked against the active protocol family, and each accepted command returns a 3-bit result code. Only one entry or exit request is outstanding toward the sequencer at a time. While a request waits for its acknowledge, the command port is closed.

The controller is built around four named states:
- ACTIVE: normal operation.
- ENTERING: an entry request is waiting for its acknowledge.
- LOW: a low-power state is held.
- EXITING: an exit request is waiting for its acknowledge.

The transitions are:
- ACTIVE→ENTERING: an accepted explicit enter, or the idle threshold is hit.
- ENTERING→LOW: the acknowledge arrives and no wake is pending.
- ENTERING→EXITING: the acknowledge arrives with a wake pending on an automatic entry.
- LOW→EXITING: a wake while in an automatic state, or an exit command while in an explicit state.
- EXITING→ACTIVE: the acknowledge arrives.

Top module: `lp_entry_ctrl`

## Requirements
- R1: After reset:
  - `pwr_state` is 0000.
  - `enter_req`, `exit_req` and `rsp_valid` are 0.
  - `cmd_ready` is 1.
  - `err_code` is 000.
  - Automatic mode is disabled.
- R2: An automatic-mode command (op 00) checks its state code against the protocol family:
  - Always allowed: 0000 (disable), 0001 and 0011.
  - LPDDR only (`proto_lpddr`=1): 0010, 0100, 1011 and 1100.
  - DDR only: 0101 and 0110.
  - An allowed code on the wrong family returns 001. Any other code returns 010. Only a command returning 000 changes the automatic setting.
- R3: An automatic-mode command with a nonzero, otherwise valid code and a threshold of 0 returns 011 and is not applied.
- R4: With automatic mode enabled and the controller in ACTIVE, `enter_req` rises after exactly `thr` consecutive clocks with `ctrl_idle`=1 and `wake_req`=0. A clock without idle, or with a wake, restarts the count from zero.
- R5: An explicit enter command (op 01) checks its state code against the protocol family:
  - DDR family: 1000, 1001 and 1010.
  - LPDDR family: 1101, 1110 and 1111.
  - An explicit code on the wrong family returns 001. Any other code returns 010.
- R6: An explicit enter command with a valid code returns 011 and is ignored if any of these holds:
  - automatic mode is enabled;
  - `ctrl_idle` is 0;
  - the controller is not in ACTIVE.
- R7: An accepted explicit enter raises `enter_req`, with `tgt_code` equal to the code, on the next clock. The request is held until `seq_ack`. After the acknowledge, `pwr_state` shows the code.
- R8: An exit command (op 10) always returns 000. In an explicit state it raises `exit_req` on the next clock. In an automatic state, or in ACTIVE, it changes nothing.
- R9: A wake in an automatic LOW state raises `exit_req` on the next clock. A wake in an explicit LOW state is ignored.
- R10: While `enter_req` or `exit_req` is high:
  - `cmd_ready` is 0;
  - an offered command produces no response and has no effect.
  - A wake that arrives during an automatic entry is remembered, so the acknowledge leads straight to EXITING.
- R11: After an automatic exit is acknowledged, the idle count rearms from zero. A new entry follows after `thr` idle clocks.
- R12: Each accepted command gives a one-clock `rsp_valid` pulse on the clock after acceptance. The command's result code is on `err_code` at the same time and is held afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command port open (no request outstanding) |
| cmd_op | input | 2 | 00 automatic mode, 01 explicit enter, 10 exit, 11 no-op |
| cmd_state | input | 4 | Requested state code |
| cmd_thr | input | 12 | Idle threshold for automatic mode |
| proto_lpddr | input | 1 | 1 = LPDDR family, 0 = DDR family |
| ctrl_idle | input | 1 | Command queue empty |
| wake_req | input | 1 | Traffic or maintenance needs the memory |
| seq_ack | input | 1 | Sequencer finished the current request |
| enter_req | output | 1 | Entry request toward the sequencer |
| exit_req | output | 1 | Exit request toward the sequencer |
| tgt_code | output | 4 | State code carried by the current request |
| pwr_state | output | 4 | Held low-power state code, 0000 when active |
| rsp_valid | output | 1 | Result pulse for an accepted command |
| err_code | output | 3 | Result of the last accepted command |

## Verification
Two pairs of events can land on the same clock.

The first pair is a wake and the end of an automatic entry. The bench pulses `wake_req` while `enter_req` is still waiting. It then acknowledges and expects `exit_req`, not a settled LOW, on the following clock.

The second pair is a command and a threshold hit. A command that arrives on the clock where the idle count would fire takes precedence and restarts the count. The bench judges this by counting clocks from the last idle edge to the rise of `enter_req`.

// File: rtl/lp_ctrl_pkg.sv
package lp_ctrl_pkg;

    localparam int CODE_W = 4;
    localparam int ERR_W  = 3;

    typedef enum logic [1:0] {
        OP_AUTO  = 2'b00,
        OP_ENTER = 2'b01,
        OP_EXIT  = 2'b10,
        OP_NOP   = 2'b11
    } lp_op_e;

    typedef enum logic [ERR_W-1:0] {
        ERR_NONE    = 3'b000,
        ERR_PROTO   = 3'b001,
        ERR_UNDEF   = 3'b010,
        ERR_BLOCKED = 3'b011
    } lp_err_e;

    typedef enum logic [1:0] {
        PS_ACTIVE   = 2'b00,
        PS_ENTERING = 2'b01,
        PS_LOW      = 2'b10,
        PS_EXITING  = 2'b11
    } lp_fsm_e;

    typedef enum logic [1:0] {
        CL_UNDEF = 2'b00,
        CL_ANY   = 2'b01,
        CL_DDR   = 2'b10,
        CL_LP    = 2'b11
    } lp_class_e;

endpackage

// File: rtl/lp_code_check.sv
module lp_code_check
    import lp_ctrl_pkg::*;
#(
    parameter int THR_W = 12
) (
    input  lp_op_e              op,
    input  logic [CODE_W-1:0]   code,
    input  logic [THR_W-1:0]    thr,
    input  logic                is_lpddr,
    input  logic                auto_on,
    input  logic                ctrl_idle,
    input  logic                fsm_active,
    output lp_err_e             err
);

    lp_class_e auto_cls;
    lp_class_e expl_cls;
    lp_class_e cls;
    logic      mismatch;

    always_comb begin
        unique case (code)
            4'b0000, 4'b0001, 4'b0011:          auto_cls = CL_ANY;
            4'b0010, 4'b0100, 4'b1011, 4'b1100: auto_cls = CL_LP;
            4'b0101, 4'b0110:                   auto_cls = CL_DDR;
            default:                            auto_cls = CL_UNDEF;
        endcase
    end

    always_comb begin
        unique case (code)
            4'b1000, 4'b1001, 4'b1010: expl_cls = CL_DDR;
            4'b1101, 4'b1110, 4'b1111: expl_cls = CL_LP;
            default:                   expl_cls = CL_UNDEF;
        endcase
    end

    assign cls      = (op == OP_ENTER) ? expl_cls : auto_cls;
    assign mismatch = (cls == CL_LP && !is_lpddr) || (cls == CL_DDR && is_lpddr);

    always_comb begin
        err = ERR_NONE;
        unique case (op)
            OP_AUTO: begin
                if (cls == CL_UNDEF)                 err = ERR_UNDEF;
                else if (mismatch)                   err = ERR_PROTO;
                else if (code != '0 && thr == '0)    err = ERR_BLOCKED;
            end
            OP_ENTER: begin
                if (cls == CL_UNDEF)                 err = ERR_UNDEF;
                else if (mismatch)                   err = ERR_PROTO;
                else if (auto_on || !ctrl_idle || !fsm_active)
                                                     err = ERR_BLOCKED;
            end
            default:                                 err = ERR_NONE;
        endcase
    end

endmodule

// File: rtl/lp_idle_timer.sv
module lp_idle_timer #(
    parameter int THR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ctrl_idle,
    input  logic             wake,
    input  logic [THR_W-1:0] thr,
    output logic             hit
);

    logic [THR_W-1:0] count;
    logic             quiet;

    assign quiet = en && ctrl_idle && !wake;
    assign hit   = quiet && (thr != '0) && (count == thr - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              count <= '0;
        else if (!quiet || hit)  count <= '0;
        else                     count <= count + 1'b1;
    end

    // R4: the running count never passes the programmed threshold
    assert_cnt_below_thr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && thr != '0) |-> (count < thr));

    // R4: a busy or woken clock leaves the count at zero
    assert_cnt_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (!ctrl_idle || wake)) |=> (count == '0));

endmodule

// File: rtl/lp_power_fsm.sv
module lp_power_fsm
    import lp_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_enter,
    input  logic [CODE_W-1:0] enter_code,
    input  logic              go_exit,
    input  logic              auto_hit,
    input  logic [CODE_W-1:0] auto_code,
    input  logic              wake,
    input  logic              seq_ack,
    output lp_fsm_e           state,
    output logic              enter_req,
    output logic              exit_req,
    output logic [CODE_W-1:0] tgt_code,
    output logic [CODE_W-1:0] pwr_state
);

    lp_fsm_e           state_q, state_d;
    logic              is_auto_q;
    logic              wake_pend_q;
    logic [CODE_W-1:0] code_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_ACTIVE:   if (go_enter || auto_hit) state_d = PS_ENTERING;
            PS_ENTERING: if (seq_ack)
                             state_d = (is_auto_q && (wake_pend_q || wake)) ? PS_EXITING : PS_LOW;
            PS_LOW:      if ((is_auto_q && wake) || (!is_auto_q && go_exit))
                             state_d = PS_EXITING;
            PS_EXITING:  if (seq_ack) state_d = PS_ACTIVE;
            default:     state_d = PS_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= PS_ACTIVE;
            is_auto_q   <= 1'b0;
            wake_pend_q <= 1'b0;
            code_q      <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == PS_ACTIVE && go_enter) begin
                code_q    <= enter_code;
                is_auto_q <= 1'b0;
            end else if (state_q == PS_ACTIVE && auto_hit) begin
                code_q    <= auto_code;
                is_auto_q <= 1'b1;
            end
            if (state_q == PS_ENTERING && !seq_ack)
                wake_pend_q <= wake_pend_q || (wake && is_auto_q);
            else
                wake_pend_q <= 1'b0;
        end
    end

    always_comb begin
        enter_req = 1'b0;
        exit_req  = 1'b0;
        pwr_state = '0;
        unique case (state_q)
            PS_ACTIVE:   ;
            PS_ENTERING: enter_req = 1'b1;
            PS_LOW:      pwr_state = code_q;
            PS_EXITING:  begin exit_req = 1'b1; pwr_state = code_q; end
            default:     ;
        endcase
    end

    assign tgt_code = code_q;
    assign state    = state_q;

    // R10: never two requests toward the sequencer at once
    assert_single_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(enter_req && exit_req));

    // R7: an entry request stays up until acknowledged
    assert_enter_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_req && !seq_ack) |=> enter_req);

    // R9: a wake in an automatic low state asks for exit next clock
    assert_wake_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_LOW && is_auto_q && wake) |=> exit_req);

    // R9: a wake in an explicit low state changes nothing
    assert_wake_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_LOW && !is_auto_q && wake && !go_exit) |=> (state_q == PS_LOW));

endmodule

// File: rtl/lp_entry_ctrl.sv
module lp_entry_ctrl
    import lp_ctrl_pkg::*;
#(
    parameter int THR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [1:0]       cmd_op,
    input  logic [3:0]       cmd_state,
    input  logic [THR_W-1:0] cmd_thr,
    input  logic             proto_lpddr,
    input  logic             ctrl_idle,
    input  logic             wake_req,
    input  logic             seq_ack,
    output logic             enter_req,
    output logic             exit_req,
    output logic [3:0]       tgt_code,
    output logic [3:0]       pwr_state,
    output logic             rsp_valid,
    output logic [2:0]       err_code
);

    lp_op_e            op;
    lp_err_e           chk_err;
    lp_fsm_e           fsm_state;
    logic              cmd_fire;
    logic              auto_on;
    logic              auto_hit;
    logic              timer_en;
    logic [CODE_W-1:0] auto_code_q;
    logic [THR_W-1:0]  auto_thr_q;
    logic [ERR_W-1:0]  err_q;
    logic              rsp_q;

    assign op        = lp_op_e'(cmd_op);
    assign cmd_ready = (fsm_state == PS_ACTIVE) || (fsm_state == PS_LOW);
    assign cmd_fire  = cmd_valid && cmd_ready;
    assign auto_on   = (auto_code_q != '0);
    assign timer_en  = (fsm_state == PS_ACTIVE) && auto_on && !cmd_fire;

    lp_code_check #(.THR_W(THR_W)) u_check (
        .op         (op),
        .code       (cmd_state),
        .thr        (cmd_thr),
        .is_lpddr   (proto_lpddr),
        .auto_on    (auto_on),
        .ctrl_idle  (ctrl_idle),
        .fsm_active (fsm_state == PS_ACTIVE),
        .err        (chk_err)
    );

    lp_idle_timer #(.THR_W(THR_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (timer_en),
        .ctrl_idle (ctrl_idle),
        .wake      (wake_req),
        .thr       (auto_thr_q),
        .hit       (auto_hit)
    );

    lp_power_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_enter   (cmd_fire && op == OP_ENTER && chk_err == ERR_NONE),
        .enter_code (cmd_state),
        .go_exit    (cmd_fire && op == OP_EXIT),
        .auto_hit   (auto_hit),
        .auto_code  (auto_code_q),
        .wake       (wake_req),
        .seq_ack    (seq_ack),
        .state      (fsm_state),
        .enter_req  (enter_req),
        .exit_req   (exit_req),
        .tgt_code   (tgt_code),
        .pwr_state  (pwr_state)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auto_code_q <= '0;
            auto_thr_q  <= '0;
            err_q       <= ERR_NONE;
            rsp_q       <= 1'b0;
        end else begin
            rsp_q <= cmd_fire;
            if (cmd_fire) begin
                err_q <= chk_err;
                if (op == OP_AUTO && chk_err == ERR_NONE) begin
                    auto_code_q <= cmd_state;
                    auto_thr_q  <= cmd_thr;
                end
            end
        end
    end

    assign rsp_valid = rsp_q;
    assign err_code  = err_q;

    // R3: a zero threshold on a nonzero code is refused
    assert_zero_thr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && op == OP_AUTO && cmd_state != '0 && cmd_thr == '0)
            |=> (err_code != ERR_NONE));

    // R10: a command offered while busy gets no response
    assert_busy_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> !rsp_valid);

    // R8: exit always answers with no error
    assert_exit_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && op == OP_EXIT) |=> (rsp_valid && err_code == ERR_NONE));

endmodule

// File: tb/lp_entry_ctrl_bench.sv
module lp_entry_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'b11;
    logic [3:0]  cmd_state = '0;
    logic [11:0] cmd_thr = '0;
    logic        proto_lpddr = 1'b0;
    logic        ctrl_idle = 1'b0;
    logic        wake_req = 1'b0;
    logic        seq_ack = 1'b0;
    logic        enter_req, exit_req, rsp_valid;
    logic [3:0]  tgt_code, pwr_state;
    logic [2:0]  err_code;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    lp_entry_ctrl u_lp_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_state(cmd_state), .cmd_thr(cmd_thr),
        .proto_lpddr(proto_lpddr), .ctrl_idle(ctrl_idle), .wake_req(wake_req),
        .seq_ack(seq_ack), .enter_req(enter_req), .exit_req(exit_req),
        .tgt_code(tgt_code), .pwr_state(pwr_state), .rsp_valid(rsp_valid),
        .err_code(err_code)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  code;
        logic [11:0] thr;
        logic        lp;
        logic        idle;
        logic [2:0]  err;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 4'b0001, 12'd4000, 1'b0, 1'b0, 3'd0},  // R2 any-family code
        '{2'd0, 4'b0010, 12'd4000, 1'b0, 1'b0, 3'd1},  // R2 LP-only on DDR
        '{2'd0, 4'b0010, 12'd4000, 1'b1, 1'b0, 3'd0},  // R2 LP-only on LP
        '{2'd0, 4'b0101, 12'd4000, 1'b1, 1'b0, 3'd1},  // R2 DDR-only on LP
        '{2'd0, 4'b0111, 12'd4000, 1'b0, 1'b0, 3'd2},  // R2 undefined
        '{2'd0, 4'b1011, 12'd4000, 1'b0, 1'b0, 3'd1},  // R2 LP self-refresh pd on DDR
        '{2'd0, 4'b0110, 12'd0,    1'b0, 1'b0, 3'd3},  // R3 zero threshold
        '{2'd0, 4'b1000, 12'd4000, 1'b0, 1'b0, 3'd2},  // R2 explicit code in auto
        '{2'd1, 4'b1000, 12'd0,    1'b0, 1'b1, 3'd3},  // R6 auto still on
        '{2'd1, 4'b1101, 12'd0,    1'b0, 1'b1, 3'd1},  // R5 LP code on DDR
        '{2'd1, 4'b0001, 12'd0,    1'b0, 1'b1, 3'd2},  // R5 undefined for enter
        '{2'd0, 4'b0000, 12'd0,    1'b0, 1'b0, 3'd0},  // R2 disable, thr ignored
        '{2'd1, 4'b1001, 12'd0,    1'b0, 1'b0, 3'd3},  // R6 not idle
        '{2'd1, 4'b1110, 12'd0,    1'b1, 1'b0, 3'd3},  // R6 not idle, LP
        '{2'd2, 4'b0000, 12'd0,    1'b0, 1'b0, 3'd0}   // R8 exit while active
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at a falling edge; returns at the falling edge after acceptance
    task automatic send(input logic [1:0] op, input logic [3:0] code, input logic [11:0] thr);
        cmd_op = op; cmd_state = code; cmd_thr = thr; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b11;
    endtask

    task automatic ack();
        seq_ack = 1'b1;
        @(negedge clk);
        seq_ack = 1'b0;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pwr_state", pwr_state, 0);
        chk("R1 enter_req", enter_req, 0);
        chk("R1 exit_req", exit_req, 0);
        chk("R1 cmd_ready", cmd_ready, 1);
        chk("R1 err_code", err_code, 0);
        chk("R1 rsp_valid", rsp_valid, 0);

        // table walk: R2 R3 R5 R6 R8 R12
        for (int v = 0; v < NV; v++) begin
            proto_lpddr = VEC[v].lp;
            ctrl_idle   = VEC[v].idle;
            send(VEC[v].op, VEC[v].code, VEC[v].thr);
            chk("R12 rsp_valid", rsp_valid, 1);
            chk($sformatf("R2/R3/R5/R6/R8 vector %0d err", v), err_code, VEC[v].err);
            ctrl_idle = 1'b0;
        end
        @(negedge clk);
        chk("R12 rsp pulse one clock", rsp_valid, 0);
        chk("R6 refused enter has no effect", enter_req, 0);

        // R7 explicit enter on DDR
        proto_lpddr = 1'b0; ctrl_idle = 1'b1;
        send(2'd1, 4'b1010, 12'd0);
        chk("R7 err", err_code, 0);
        chk("R7 enter_req", enter_req, 1);
        chk("R7 tgt_code", tgt_code, 4'b1010);
        chk("R10 cmd_ready low", cmd_ready, 0);
        // R10 command while busy is dropped
        send(2'd2, 4'b0000, 12'd0);
        chk("R10 no rsp while busy", rsp_valid, 0);
        chk("R7 request held", enter_req, 1);
        ack();
        chk("R7 pwr_state after ack", pwr_state, 4'b1010);
        chk("R7 enter_req dropped", enter_req, 0);
        // R9 wake ignored in explicit state
        wake_req = 1'b1; @(negedge clk); wake_req = 1'b0; @(negedge clk);
        chk("R9 explicit wake exit_req", exit_req, 0);
        chk("R9 explicit wake pwr_state", pwr_state, 4'b1010);
        // R8 exit leaves explicit state
        send(2'd2, 4'b0000, 12'd0);
        chk("R8 exit err", err_code, 0);
        chk("R8 exit_req", exit_req, 1);
        ack();
        chk("R8 back to active", pwr_state, 0);

        // R4 automatic entry after thr idle clocks
        ctrl_idle = 1'b0;
        send(2'd0, 4'b0011, 12'd3);
        chk("R4 auto config err", err_code, 0);
        ctrl_idle = 1'b1;
        wait_n(2);
        chk("R4 no entry before thr", enter_req, 0);
        wait_n(1);
        chk("R4 entry at thr", enter_req, 1);
        chk("R4 tgt_code", tgt_code, 4'b0011);
        ack();
        chk("R4 pwr_state auto", pwr_state, 4'b0011);
        // R8 exit command does not end an automatic state
        send(2'd2, 4'b0000, 12'd0);
        chk("R8 exit on auto err", err_code, 0);
        chk("R8 exit on auto no request", exit_req, 0);
        chk("R8 exit on auto state kept", pwr_state, 4'b0011);
        // R9 wake exits automatic state next clock
        wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
        chk("R9 wake exit_req", exit_req, 1);
        // R11 rearm from zero after ack, idle still high
        ack();
        chk("R11 active after ack", pwr_state, 0);
        wait_n(2);
        chk("R11 no early re-entry", enter_req, 0);
        wait_n(1);
        chk("R11 re-entry after thr", enter_req, 1);

        // R10 wake during entry is remembered
        wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
        ctrl_idle = 1'b0;
        ack();
        chk("R10 pending wake exit_req", exit_req, 1);
        chk("R10 pending wake enter_req", enter_req, 0);
        ack();
        chk("R10 back to active", pwr_state, 0);

        // R4 busy clock restarts the count
        ctrl_idle = 1'b1; wait_n(2);
        ctrl_idle = 1'b0; wait_n(1);
        ctrl_idle = 1'b1; wait_n(2);
        chk("R4 restart no early entry", enter_req, 0);
        wait_n(1);
        chk("R4 restart entry at thr", enter_req, 1);
        ctrl_idle = 1'b0;
        ack();
        wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
        ack();

        // R4 a command on the hit clock wins and restarts the count
        ctrl_idle = 1'b1; wait_n(2);
        send(2'd0, 4'b0011, 12'd3);
        chk("R4 collision no entry", enter_req, 0);
        wait_n(2);
        chk("R4 collision still counting", enter_req, 0);
        wait_n(1);
        chk("R4 collision entry after restart", enter_req, 1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule